// File: doc/BRIEF.md
# Dual-Rail Word Completion Detector

This block watches an n-bit word carried on dual-rail wires and reports when the whole word has arrived and, later, when the whole word has been withdrawn. Each bit travels on a pair of rails. A pair with both rails low is the empty spacer. A pair with exactly one rail high carries a data value. The detector raises a single completion flag once every pair carries a value. It lowers that flag only after every pair has gone back to the spacer.

Each pair is first reduced to a presence bit by ORing its two rails. The presence bits are then combined by one wide Muller C-element. This element has hysteresis: it moves high only when all inputs are high, moves low only when all inputs are low, and otherwise keeps its value. The held state is a register clocked by a sampling clock. A pipeline controller uses the flag to release or reset the stage in front of it. A separate flag reports any pair driven to the forbidden both-high code.

Top module: `dr_done_detect`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `done_o` and `illegal_o` are 0 after that edge.
- R2: Pair i occupies `rails_i[2i+1:2i]`. Bit 2i is the zero rail and bit 2i+1 is the one rail. The codes are 00 spacer, 01 logic 0, 10 logic 1 and 11 illegal. A pair counts as present when either of its rails is high.
- R3: If all WIDTH pairs are present at a clock edge, `done_o` is 1 after that edge.
- R4: If all WIDTH pairs are spacers at a clock edge, `done_o` is 0 after that edge.
- R5: If some pairs are present and others are spacers at a clock edge, `done_o` keeps its previous value.
- R6: Going from spacer to valid, `done_o` stays 0 while any pair is still a spacer. It rises only in the cycle after the last pair becomes present, whatever order the pairs arrive in and whatever values they carry.
- R7: Going from valid to spacer, `done_o` stays 1 while any pair is still present. It falls only in the cycle after the last pair returns to spacer, whatever the order.
- R8: `illegal_o` is 1 after a clock edge at which any pair is 11, and 0 after a clock edge at which no pair is 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| rails_i | input | 2*WIDTH | Dual-rail word, two rails per bit |
| done_o | output | 1 | Completion flag with hysteresis |
| illegal_o | output | 1 | A pair carried the both-high code in the last sample |

## Verification
The hardest case to reach is a word that is only partly present. Here the output must hold its old value in both directions. An error that misses one pair, or that decides on the wrong input count, shows up only for some arrival orders. The stimulus therefore raises pairs one at a time in shuffled orders and with mixed data values. It then withdraws them in a fresh shuffled order and checks the flag after every single step. It also raises a partial word and withdraws it before completion, which shows that no transition happened early.

// File: rtl/dr_pkg.sv
package dr_pkg;

    typedef struct packed {
        logic one_rail;
        logic zero_rail;
    } rail_pair_t;

    localparam rail_pair_t PAIR_SPACER = '{one_rail: 1'b0, zero_rail: 1'b0};
    localparam rail_pair_t PAIR_ZERO   = '{one_rail: 1'b0, zero_rail: 1'b1};
    localparam rail_pair_t PAIR_ONE    = '{one_rail: 1'b1, zero_rail: 1'b0};

    function automatic logic pair_present(rail_pair_t p);
        return p.one_rail | p.zero_rail;
    endfunction

    function automatic logic pair_illegal(rail_pair_t p);
        return p.one_rail & p.zero_rail;
    endfunction

endpackage

// File: rtl/rail_presence.sv
module rail_presence
    import dr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [2*WIDTH-1:0] rails_i,
    output logic [WIDTH-1:0]   present_o,
    output logic [WIDTH-1:0]   bad_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_pair
        rail_pair_t pair;
        assign pair         = rail_pair_t'(rails_i[2*g+1:2*g]);
        assign present_o[g] = pair_present(pair);
        assign bad_o[g]     = pair_illegal(pair);
    end

endmodule

// File: rtl/c_merge.sv
module c_merge #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] agree_i,
    output logic             state_o
);

    logic all_high;
    logic all_low;

    assign all_high = &agree_i;
    assign all_low  = ~|agree_i;

    always_ff @(posedge clk) begin
        if (rst)           state_o <= 1'b0;
        else if (all_high) state_o <= 1'b1;
        else if (all_low)  state_o <= 1'b0;
    end

    // R3
    set_on_unanimous_chk: assert property (@(posedge clk) disable iff (rst)
        all_high |=> state_o);

    // R4
    clear_on_unanimous_chk: assert property (@(posedge clk) disable iff (rst)
        all_low |=> !state_o);

    // R5
    hold_on_mixed_chk: assert property (@(posedge clk) disable iff (rst)
        (!all_high && !all_low) |=> $stable(state_o));

endmodule

// File: rtl/dr_done_detect.sv
module dr_done_detect
    import dr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2*WIDTH-1:0] rails_i,
    output logic               done_o,
    output logic               illegal_o
);

    logic [WIDTH-1:0] present;
    logic [WIDTH-1:0] bad;

    rail_presence #(.WIDTH(WIDTH)) u_presence (
        .rails_i   (rails_i),
        .present_o (present),
        .bad_o     (bad)
    );

    c_merge #(.WIDTH(WIDTH)) u_merge (
        .clk     (clk),
        .rst     (rst),
        .agree_i (present),
        .state_o (done_o)
    );

    always_ff @(posedge clk) begin
        if (rst) illegal_o <= 1'b0;
        else     illegal_o <= |bad;
    end

    // R8
    illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (rails_i[1:0] == 2'b11) |=> illegal_o);

    // R6
    no_early_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!done_o && (rails_i[1:0] == 2'b00)) |=> !done_o);

    // R7
    no_early_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && (rails_i[1:0] != 2'b00)) |=> done_o);

endmodule

// File: tb/test_dr_done_detect.sv
module test_dr_done_detect;

    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst;
    logic [2*W-1:0] rails;
    logic           done_o;
    logic           illegal_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    dr_done_detect #(.WIDTH(W)) i_dr_done_detect (
        .clk       (clk),
        .rst       (rst),
        .rails_i   (rails),
        .done_o    (done_o),
        .illegal_o (illegal_o)
    );

    task automatic check(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_pair(int i, logic [1:0] code);
        rails[2*i +: 2] = code;
    endtask

    task automatic shuffle(ref int ord[W]);
        for (int i = 0; i < W; i++) ord[i] = i;
        for (int i = W - 1; i > 0; i--) begin
            int j;
            int t;
            j = $urandom_range(i, 0);
            t = ord[i];
            ord[i] = ord[j];
            ord[j] = t;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        rails = '1;
        @(negedge clk);
        check("R1 done after reset", done_o, 1'b0);
        check("R1 illegal after reset", illegal_o, 1'b0);
        rails = '0;
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_fill_random();
        int ord[W];
        shuffle(ord);
        for (int k = 0; k < W; k++) begin
            set_pair(ord[k], $urandom_range(1, 0) ? 2'b10 : 2'b01);
            @(negedge clk);
            if (k < W - 1) check("R6 no rise before last pair", done_o, 1'b0);
            else           check("R6 rise on last pair", done_o, 1'b1);
        end
    endtask

    task automatic t_drain_random();
        int ord[W];
        shuffle(ord);
        for (int k = 0; k < W; k++) begin
            set_pair(ord[k], 2'b00);
            @(negedge clk);
            if (k < W - 1) check("R7 no fall before last spacer", done_o, 1'b1);
            else           check("R7 fall on last spacer", done_o, 1'b0);
        end
    endtask

    task automatic t_whole_word();
        rails = {W{2'b01}};
        @(negedge clk);
        check("R3 all zeros valid", done_o, 1'b1);
        rails = {W{2'b10}};
        @(negedge clk);
        check("R2 value change stays done", done_o, 1'b1);
        rails = '0;
        @(negedge clk);
        check("R4 all spacer", done_o, 1'b0);
    endtask

    task automatic t_partial_bounce();
        rails = '0;
        set_pair(0, 2'b01);
        set_pair(W - 1, 2'b10);
        @(negedge clk);
        check("R5 partial holds low", done_o, 1'b0);
        rails = '0;
        @(negedge clk);
        check("R5 back to spacer low", done_o, 1'b0);
        rails = {W{2'b10}};
        @(negedge clk);
        rails = '0;
        set_pair(3, 2'b01);
        @(negedge clk);
        check("R5 partial holds high", done_o, 1'b1);
        rails = '0;
        @(negedge clk);
        check("R4 clear after hold", done_o, 1'b0);
    endtask

    task automatic t_illegal();
        rails = '0;
        set_pair(2, 2'b11);
        @(negedge clk);
        check("R8 illegal raised", illegal_o, 1'b1);
        check("R5 illegal pair alone holds low", done_o, 1'b0);
        rails = {W{2'b01}};
        set_pair(5, 2'b11);
        @(negedge clk);
        check("R2 both-high counts present", done_o, 1'b1);
        check("R8 illegal in full word", illegal_o, 1'b1);
        rails = {W{2'b01}};
        @(negedge clk);
        check("R8 illegal clears", illegal_o, 1'b0);
        rails = '0;
        @(negedge clk);
        check("R4 clear after illegal test", done_o, 1'b0);
    endtask

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        rails = '0;
        void'($urandom(17));
        t_reset();
        for (int r = 0; r < 4; r++) begin
            t_fill_random();
            t_drain_random();
        end
        t_whole_word();
        t_partial_bounce();
        t_illegal();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule